// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This unit sits next to the program counter of a small processor and decides where instruction fetch goes when control flow is forced by reset, by an accepted interrupt, or by a return from a handler. Interrupt requests come in on a vector with one bit per source. The unit considers them only at instruction boundaries, and only while its global enable flag is set. It then picks one source and emits a one-cycle redirect strobe with the address of that source's table slot. In the same cycle it emits a push strobe carrying the address that fetch would have used next, and a one-hot acknowledge to the chosen source.

The vector table holds eleven consecutive one-word slots. Slot 0 is reset. Request bit k-1 owns slot k, for k = 1..10. The table is based at address zero, or at a relocation base supplied on an input when the relocation select is high; the reset slot moves with it. Each slot is expected to hold a jump to its handler, so the unit only points fetch at the slot. Accepting an interrupt clears the global enable so that handlers do not nest. A return strobe redirects fetch to the popped address and sets the enable again. Software can also write the enable directly.

All outputs are registered. An input sampled at a rising edge shows up on the outputs just after that edge.

Top module: `ivd_dispatch`

## Requirements
- R1: After reset is released, the unit issues exactly one redirect to the reset vector (slot 0) before anything else. It asserts no push and no acknowledge, and the enable flag reads 0.
- R2: With reloc_sel low, the redirect address for request bit k-1 is k, for k = 1..10.
- R3: With reloc_sel high, every vector address, including the reset vector, is reloc_base plus the slot number.
- R4: When several enabled requests are pending, the one with the lowest slot number is taken. irq_ack is one-hot on that request bit and is zero otherwise.
- R5: On acceptance, push_en pulses and push_addr equals the next_pc value present at the accepting boundary.
- R6: Requests are accepted only in a cycle where insn_boundary is high. A request held while insn_boundary is low causes no redirect until the next boundary.
- R7: While the enable flag is 0, pending requests cause no redirect, push or acknowledge.
- R8: Acceptance clears the enable flag in the same cycle that the redirect appears.
- R9: reti_strobe causes a redirect to reti_addr, sets the enable flag, and asserts no push and no acknowledge. A request in that same cycle is not accepted.
- R10: ie_write loads ie_value into the enable flag when no acceptance or return occurs in that cycle.
- R11: redirect, push_en and irq_ack are single-cycle pulses per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 10 | Pending enabled requests; bit k-1 owns slot k |
| insn_boundary | input | 1 | High when the core is between instructions |
| next_pc | input | 16 | Address of the instruction that would execute next |
| reloc_sel | input | 1 | Selects the relocated table base |
| reloc_base | input | 16 | Relocated table base address |
| reti_strobe | input | 1 | Return-from-interrupt request |
| reti_addr | input | 16 | Popped return address |
| ie_write | input | 1 | Software write of the enable flag |
| ie_value | input | 1 | Value for the software write |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | 16 | Redirect target |
| push_en | output | 1 | Push the return address |
| push_addr | output | 16 | Return address to push |
| irq_ack | output | 10 | One-hot acknowledge to the taken source |
| gie | output | 1 | Global interrupt enable flag |

## Verification
The bench takes every source with the table at zero and again relocated, and checks that each redirect lands on the base plus the slot number. A design that offsets the index by one, or that ignores the relocated base, would land in a neighbouring slot or in the unrelocated table. It applies all 1023 non-empty request patterns and checks that the lowest set bit wins with a one-hot acknowledge. A reversed priority, or an acknowledge with several bits set, would show up at once. Other checks cover requests held without a boundary, requests while the enable is clear, and a return in the same cycle as a request. In these cases a design that sampled mid-instruction, ignored the mask, or let handlers nest would redirect when it must not. The pushed address is compared with the next_pc value at the boundary, so a design that saved the finished instruction's address would fail.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_IRQ   = 2'd2,
    EV_RETI  = 2'd3
  } ivd_event_e;
endpackage

// File: rtl/ivd_rst_sync.sv
module ivd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ivd_prio_pick.sv
module ivd_prio_pick #(
  parameter int N_IRQ  = 10,
  parameter int SLOT_W = $clog2(N_IRQ + 1)
) (
  input  logic [N_IRQ-1:0]  req,
  output logic [N_IRQ-1:0]  grant,
  output logic [SLOT_W-1:0] slot,
  output logic              any
);
  logic [N_IRQ:0] lower_any;

  assign lower_any[0] = 1'b0;

  // Lowest bit wins: a request is granted only if no lower bit is set.
  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_chain
    assign grant[gi]       = req[gi] & ~lower_any[gi];
    assign lower_any[gi+1] = lower_any[gi] | req[gi];
  end

  assign any = lower_any[N_IRQ];

  always_comb begin
    slot = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (grant[i]) slot = slot | SLOT_W'(i + 1);
    end
  end
endmodule

// File: rtl/ivd_vector_calc.sv
module ivd_vector_calc #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 4
) (
  input  logic              reloc_sel,
  input  logic [ADDR_W-1:0] reloc_base,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [ADDR_W-1:0] base;

  assign base     = reloc_sel ? reloc_base : '0;
  assign vec_addr = base + {{(ADDR_W-SLOT_W){1'b0}}, slot};
endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch #(
  parameter int ADDR_W = 16,
  parameter int N_IRQ  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              insn_boundary,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              reloc_sel,
  input  logic [ADDR_W-1:0] reloc_base,
  input  logic              reti_strobe,
  input  logic [ADDR_W-1:0] reti_addr,
  input  logic              ie_write,
  input  logic              ie_value,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              push_en,
  output logic [ADDR_W-1:0] push_addr,
  output logic [N_IRQ-1:0]  irq_ack,
  output logic              gie
);
  import ivd_pkg::*;

  localparam int SLOT_W = $clog2(N_IRQ + 1);

  logic              rst_sync_n;
  logic [N_IRQ-1:0]  grant;
  logic [SLOT_W-1:0] pick_slot, slot_sel;
  logic              pick_any;
  logic [ADDR_W-1:0] vec_addr;

  logic              boot_q, boot_d;
  logic              gie_q, gie_d;
  logic              redir_q, redir_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              push_q, push_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [N_IRQ-1:0]  ack_q, ack_d;
  ivd_event_e        ev;

  ivd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ivd_prio_pick #(.N_IRQ(N_IRQ), .SLOT_W(SLOT_W)) u_pick (
    .req   (irq_req),
    .grant (grant),
    .slot  (pick_slot),
    .any   (pick_any)
  );

  assign slot_sel = (ev == EV_RESET) ? '0 : pick_slot;

  ivd_vector_calc #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_vec (
    .reloc_sel  (reloc_sel),
    .reloc_base (reloc_base),
    .slot       (slot_sel),
    .vec_addr   (vec_addr)
  );

  // Event selection. Priority: reset, then return, then interrupt.
  always_comb begin
    if (boot_q)                                   ev = EV_RESET;
    else if (reti_strobe)                         ev = EV_RETI;
    else if (insn_boundary && gie_q && pick_any)  ev = EV_IRQ;
    else                                          ev = EV_NONE;
  end

  // Next-state logic
  always_comb begin
    boot_d  = 1'b0;
    gie_d   = gie_q;
    redir_d = 1'b0;
    raddr_d = raddr_q;
    push_d  = 1'b0;
    paddr_d = paddr_q;
    ack_d   = '0;
    unique case (ev)
      EV_RESET: begin
        gie_d   = 1'b0;
        redir_d = 1'b1;
        raddr_d = vec_addr;
      end
      EV_RETI: begin
        gie_d   = 1'b1;
        redir_d = 1'b1;
        raddr_d = reti_addr;
      end
      EV_IRQ: begin
        gie_d   = 1'b0;
        redir_d = 1'b1;
        raddr_d = vec_addr;
        push_d  = 1'b1;
        paddr_d = next_pc;
        ack_d   = grant;
      end
      default: begin
        if (ie_write) gie_d = ie_value;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      boot_q  <= 1'b1;
      gie_q   <= 1'b0;
      redir_q <= 1'b0;
      raddr_q <= '0;
      push_q  <= 1'b0;
      paddr_q <= '0;
      ack_q   <= '0;
    end else begin
      boot_q  <= boot_d;
      gie_q   <= gie_d;
      redir_q <= redir_d;
      raddr_q <= raddr_d;
      push_q  <= push_d;
      paddr_q <= paddr_d;
      ack_q   <= ack_d;
    end
  end

  assign redirect      = redir_q;
  assign redirect_addr = raddr_q;
  assign push_en       = push_q;
  assign push_addr     = paddr_q;
  assign irq_ack       = ack_q;
  assign gie           = gie_q;

  // Assertions
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  p_push_has_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (redirect && $countones(irq_ack) == 1));

  p_accept_clears_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !gie);

  p_accept_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && !insn_boundary) |=> !push_en);

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && !gie) |=> !push_en);

  p_reti_no_push_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reti_strobe |=> (redirect && !push_en && gie));

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> !push_en);
endmodule

// File: tb/tb_ivd_dispatch.sv
`timescale 1ns/1ps
module tb_ivd_dispatch;
  localparam int AW = 16;
  localparam int NI = 10;
  localparam logic [AW-1:0] RBASE = 16'h1E00;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_req;
  logic          insn_boundary;
  logic [AW-1:0] next_pc;
  logic          reloc_sel;
  logic [AW-1:0] reloc_base;
  logic          reti_strobe;
  logic [AW-1:0] reti_addr;
  logic          ie_write, ie_value;
  logic          redirect, push_en, gie;
  logic [AW-1:0] redirect_addr, push_addr;
  logic [NI-1:0] irq_ack;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ivd_dispatch #(.ADDR_W(AW), .N_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .next_pc(next_pc), .reloc_sel(reloc_sel), .reloc_base(reloc_base),
    .reti_strobe(reti_strobe), .reti_addr(reti_addr), .ie_write(ie_write),
    .ie_value(ie_value), .redirect(redirect), .redirect_addr(redirect_addr),
    .push_en(push_en), .push_addr(push_addr), .irq_ack(irq_ack), .gie(gie)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    irq_req = '0; insn_boundary = 1'b0; next_pc = '0; reti_strobe = 1'b0;
    reti_addr = '0; ie_write = 1'b0; ie_value = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Accept an interrupt and check every output; then return from it.
  task automatic accept_and_return(input logic [NI-1:0] mask, input bit rel, input logic [AW-1:0] pc);
    int lo = 0;
    logic [AW-1:0] exp_addr;
    for (int b = NI - 1; b >= 0; b--) if (mask[b]) lo = b;
    exp_addr = (rel ? RBASE : 16'h0) + AW'(lo + 1);
    @(negedge clk);
    irq_req = mask; insn_boundary = 1'b1; next_pc = pc; reloc_sel = rel;
    step();
    chk(redirect === 1'b1, "R2/R3 redirect", redirect, 1);
    chk(redirect_addr === exp_addr, rel ? "R3 vector" : "R2 vector", redirect_addr, exp_addr);
    chk(irq_ack === (NI'(1) << lo), "R4 ack", irq_ack, NI'(1) << lo);
    chk(push_en === 1'b1 && push_addr === pc, "R5 push", push_addr, pc);
    chk(gie === 1'b0, "R8 gie cleared", gie, 0);
    @(negedge clk);
    idle_inputs();
    step();
    chk(redirect === 1'b0 && push_en === 1'b0 && irq_ack === '0, "R11 pulse", {redirect, push_en}, 0);
    @(negedge clk);
    reti_strobe = 1'b1; reti_addr = pc;
    step();
    chk(redirect === 1'b1 && redirect_addr === pc && push_en === 1'b0 && gie === 1'b1,
        "R9 reti", redirect_addr, pc);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    idle_inputs();
    reloc_sel = 1'b1; reloc_base = RBASE;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(redirect === 1'b0 && gie === 1'b0, "R1 in reset", redirect, 0);
    @(negedge clk) rst_n = 1'b1;
    // R1 + R3: relocated reset vector, no push
    seen = 0;
    for (int c = 0; c < 6 && !seen; c++) begin
      step();
      if (redirect) begin
        seen = 1;
        chk(redirect_addr === RBASE, "R1/R3 reset vector", redirect_addr, RBASE);
        chk(push_en === 1'b0 && irq_ack === '0 && gie === 1'b0, "R1 no push", push_en, 0);
      end
    end
    chk(seen, "R1 reset redirect seen", seen, 1);

    // R1 with table at zero
    @(negedge clk) rst_n = 1'b0; reloc_sel = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    seen = 0;
    for (int c = 0; c < 6 && !seen; c++) begin
      step();
      if (redirect) begin
        seen = 1;
        chk(redirect_addr === 16'h0000, "R1 reset vector", redirect_addr, 0);
      end
    end
    chk(seen, "R1 reset redirect seen", seen, 1);
    step();

    // R7: masked
    @(negedge clk) irq_req = 10'h3FF; insn_boundary = 1'b1;
    step(); step();
    chk(redirect === 1'b0 && push_en === 1'b0 && irq_ack === '0, "R7 masked", redirect, 0);
    @(negedge clk) idle_inputs();

    // R10: software enable write
    @(negedge clk) ie_write = 1'b1; ie_value = 1'b1;
    step();
    chk(gie === 1'b1, "R10 set", gie, 1);
    @(negedge clk) ie_value = 1'b0;
    step();
    chk(gie === 1'b0, "R10 clear", gie, 0);
    @(negedge clk) ie_value = 1'b1;
    step();
    @(negedge clk) idle_inputs();

    // R6: request held without a boundary
    @(negedge clk) irq_req = 10'h010;
    step(); step(); step();
    chk(redirect === 1'b0 && push_en === 1'b0, "R6 no boundary", redirect, 0);
    @(negedge clk) insn_boundary = 1'b1; next_pc = 16'h0123;
    step();
    chk(redirect === 1'b1 && redirect_addr === 16'd5, "R6 at boundary", redirect_addr, 5);
    @(negedge clk) idle_inputs(); reti_strobe = 1'b1; reti_addr = 16'h0123;
    step();
    @(negedge clk) idle_inputs();

    // R9: return and request in the same cycle
    @(negedge clk) ie_write = 1'b1; ie_value = 1'b0;
    @(negedge clk) ie_write = 1'b0;
    reti_strobe = 1'b1; reti_addr = 16'h0456; irq_req = 10'h001; insn_boundary = 1'b1;
    step();
    chk(redirect_addr === 16'h0456 && push_en === 1'b0 && irq_ack === '0 && gie === 1'b1,
        "R9 reti wins", redirect_addr, 16'h0456);
    @(negedge clk) idle_inputs();

    // R2/R3: every source, both table positions
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < NI; k++)
        accept_and_return(NI'(1) << k, bit'(r), AW'(16'h2000 + 16'(k * 3 + r)));

    // R4: every request pattern
    for (int m = 1; m < (1 << NI); m++)
      accept_and_return(NI'(m), bit'(m & 1), AW'(m * 7));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule